// File: doc/BRIEF.md
# Multi-mode program trace encoder

This block sits beside a processor core and watches its retirement port. Each cycle it may see one retired instruction: its program counter, a class code and, for a change of flow, the address that execution continues at. From this it builds program trace messages under one of three emission policies chosen at run time. Flow mode reports only the points where sequential execution is broken. Sync mode reports every cycle. Function mode reports only calls and returns, and can hide calls to very short functions together with their returns.

Every message carries a kind, a 32-bit address and the value of a free-running cycle tag. Messages are written to a small queue that feeds a valid/ready output stream. When the queue cannot take a message, that message is lost, a sticky overflow flag is raised and the next stored message is marked as a resynchronisation point. A change of mode, or switching the encoder on, forces one sync message so that a decoder can re-anchor. The enable gates program trace alone and acts independently of any other trace source.

Top module: `ptrace_encoder`

## Requirements
- R1: With `mode_sel`=0 (flow; the unused code 3 behaves the same), a retired instruction of class jump (1), branch (2), call (3), return (4) or exception (5) gives one message whose address is `rt_target`. Jumps and branches have kind 1, calls kind 2, returns kind 3 and exceptions kind 4. Sequential instructions (class 0) give no message.
- R2: With `mode_sel`=1 (sync), every enabled cycle gives one message of kind 0. Its address is `rt_pc` when an instruction retires in that cycle, whatever its class, and otherwise the last retired program counter.
- R3: With `mode_sel`=2 (function), only calls (kind 2, address `rt_target`) and returns (kind 3, address `rt_target`) give messages. Jumps, branches, exceptions and sequential instructions are dropped.
- R4: In function mode with `short_limit`=N>0, a call is held back. If a return retires after fewer than N further instructions, neither the call nor the return is reported.
- R5: A held call is released with its own target and its own cycle tag in the cycle in which the N-th instruction after it retires, or in the cycle of a later call, which then becomes the held one. A release always comes before any later message.
- R6: With `short_limit`=0, each call is reported in its own cycle.
- R7: While `trace_en` is low no new messages are produced, and messages already queued still drain. The cycle after `trace_en` is first seen high gives one sync message (kind 0, current program counter).
- R8: A value of `mode_sel` seen in cycle t governs from cycle t+1. Cycle t+1 gives exactly one kind-0 message carrying `rt_pc`, in place of any event of that cycle. A call held in function mode is dropped at that point.
- R9: A message generated in cycle t is offered on the output in cycle t+1. Messages leave in order. Up to 4 wait while `m_ready` is low, and the offered message stays unchanged until it is taken.
- R10: A message generated while the queue is full and not being read is lost and `overflow` becomes 1 until reset. The next message that is stored has `m_resync`=1, and later messages have 0.
- R11: `m_tag` is the value of a counter that advances once per clock cycle, taken in the cycle in which the event retired. The tags of two messages therefore differ by the number of cycles between their events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trace_en | input | 1 | Program trace enable |
| mode_sel | input | 2 | 0 flow, 1 sync, 2 function, 3 as flow |
| short_limit | input | 4 | Short-function window N in instructions, 0 turns the filter off |
| rt_valid | input | 1 | One instruction retired this cycle |
| rt_pc | input | 32 | Program counter of the retired instruction |
| rt_class | input | 3 | 0 seq, 1 jump, 2 branch, 3 call, 4 return, 5 exception |
| rt_target | input | 32 | Address that execution continues at after a change of flow |
| m_valid | output | 1 | Message offered |
| m_ready | input | 1 | Consumer takes the offered message |
| m_kind | output | 3 | 0 sync, 1 jump/branch, 2 call, 3 return, 4 exception |
| m_addr | output | 32 | Target or current address |
| m_tag | output | 16 | Cycle tag of the event |
| m_resync | output | 1 | First message stored after a loss |
| overflow | output | 1 | Sticky: a message was lost |

## Verification
The hardest state to reach from the ports is a held call whose fate depends on what follows it: a return inside the window, a second call, or the N-th instruction. The bench sets a window of three and drives each of these sequences cycle by cycle, checking the released call's tag against its own cycle. Losing messages also needs a full queue, so the bench holds `m_ready` low through a burst of six jumps and then lets the queue drain before sending a further jump, whose message must be the one marked for resynchronisation.

// File: rtl/ptrace_pkg.sv
package ptrace_pkg;

   typedef enum logic [2:0] {
      CLS_SEQ    = 3'd0,
      CLS_JUMP   = 3'd1,
      CLS_BRANCH = 3'd2,
      CLS_CALL   = 3'd3,
      CLS_RET    = 3'd4,
      CLS_EXC    = 3'd5
   } ret_class_e;

   typedef enum logic [1:0] {
      MODE_FLOW = 2'd0,
      MODE_SYNC = 2'd1,
      MODE_FUNC = 2'd2
   } emit_mode_e;

   localparam logic [2:0] KIND_SYNC = 3'd0;
   localparam logic [2:0] KIND_JUMP = 3'd1;
   localparam logic [2:0] KIND_CALL = 3'd2;
   localparam logic [2:0] KIND_RET  = 3'd3;
   localparam logic [2:0] KIND_EXC  = 3'd4;

   function automatic logic is_break(input logic [2:0] cls);
      case (cls)
         CLS_JUMP, CLS_BRANCH, CLS_CALL, CLS_RET, CLS_EXC: is_break = 1'b1;
         default:                                          is_break = 1'b0;
      endcase
   endfunction

   function automatic logic [2:0] class_to_kind(input logic [2:0] cls);
      case (cls)
         CLS_JUMP, CLS_BRANCH: class_to_kind = KIND_JUMP;
         CLS_CALL:             class_to_kind = KIND_CALL;
         CLS_RET:              class_to_kind = KIND_RET;
         CLS_EXC:              class_to_kind = KIND_EXC;
         default:              class_to_kind = KIND_SYNC;
      endcase
   endfunction

endpackage

// File: rtl/ptrace_mode_ctl.sv
module ptrace_mode_ctl
   import ptrace_pkg::*;
#(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trace_en,
   input  logic [MODE_W-1:0] mode_sel,
   output logic              active,
   output logic [MODE_W-1:0] mode_q,
   output logic              force_sync
);

   logic en_q;
   logic force_q;

   initial begin
      assert (MODE_W == 2) else $error("ptrace_mode_ctl: MODE_W must be 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         en_q    <= 1'b0;
         force_q <= 1'b0;
      end else begin
         mode_q  <= mode_sel;
         en_q    <= trace_en;
         force_q <= trace_en && ((mode_sel != mode_q) || !en_q);
      end
   end

   assign active     = en_q;
   assign force_sync = force_q;

   // R8: a sampled mode change while running leads to a forced sync next cycle
   assert_force_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (trace_en && en_q && (mode_sel != mode_q)) |=> (force_sync && active));

   // R7: switching on leads to a forced sync next cycle
   assert_force_on_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (trace_en && !active) |=> force_sync);

endmodule

// File: rtl/ptrace_call_filter.sv
module ptrace_call_filter
   import ptrace_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int TAG_W     = 16,
   parameter int LIM_W     = 4,
   parameter bit FILTER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_valid,
   input  logic [2:0]        in_class,
   input  logic [ADDR_W-1:0] in_target,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [LIM_W-1:0]  limit,
   output logic              out_valid,
   output logic [2:0]        out_kind,
   output logic [ADDR_W-1:0] out_addr,
   output logic [TAG_W-1:0]  out_tag
);

   logic is_call;
   logic is_ret;
   logic is_other;

   assign is_call  = in_valid && (in_class == CLS_CALL);
   assign is_ret   = in_valid && (in_class == CLS_RET);
   assign is_other = in_valid && !is_call && !is_ret;

   generate
      if (FILTER_EN) begin : g_filter
         logic              pend_q,  pend_d;
         logic [ADDR_W-1:0] paddr_q, paddr_d;
         logic [TAG_W-1:0]  ptag_q,  ptag_d;
         logic [LIM_W-1:0]  cnt_q,   cnt_d;
         logic [LIM_W:0]    cnt_next;
         logic              filt_on;

         assign filt_on  = (limit != '0);
         assign cnt_next = {1'b0, cnt_q} + 1'b1;

         always_comb begin
            out_valid = 1'b0;
            out_kind  = KIND_CALL;
            out_addr  = in_target;
            out_tag   = in_tag;
            pend_d    = pend_q;
            paddr_d   = paddr_q;
            ptag_d    = ptag_q;
            cnt_d     = cnt_q;
            if (flush) begin
               pend_d = 1'b0;
            end else if (pend_q) begin
               if (!filt_on) begin
                  out_valid = 1'b1;
                  out_addr  = paddr_q;
                  out_tag   = ptag_q;
                  pend_d    = 1'b0;
               end else if (is_call) begin
                  out_valid = 1'b1;
                  out_addr  = paddr_q;
                  out_tag   = ptag_q;
                  paddr_d   = in_target;
                  ptag_d    = in_tag;
                  cnt_d     = '0;
               end else if (is_ret) begin
                  pend_d = 1'b0;
               end else if (is_other) begin
                  if (cnt_next >= {1'b0, limit}) begin
                     out_valid = 1'b1;
                     out_addr  = paddr_q;
                     out_tag   = ptag_q;
                     pend_d    = 1'b0;
                  end else begin
                     cnt_d = cnt_next[LIM_W-1:0];
                  end
               end
            end else begin
               if (is_call && filt_on) begin
                  pend_d  = 1'b1;
                  paddr_d = in_target;
                  ptag_d  = in_tag;
                  cnt_d   = '0;
               end else if (is_call) begin
                  out_valid = 1'b1;
               end else if (is_ret) begin
                  out_valid = 1'b1;
                  out_kind  = KIND_RET;
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q  <= 1'b0;
               paddr_q <= '0;
               ptag_q  <= '0;
               cnt_q   <= '0;
            end else begin
               pend_q  <= pend_d;
               paddr_q <= paddr_d;
               ptag_q  <= ptag_d;
               cnt_q   <= cnt_d;
            end
         end

         // R4: a return inside the window cancels the held call silently
         assert_cancel_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q && filt_on && is_ret && !flush) |-> (!out_valid ##1 !pend_q));

         // R5: a later call releases the held one and is held in its place
         assert_nested_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q && filt_on && is_call && !flush) |-> (out_valid ##1 pend_q));
      end else begin : g_pass
         always_comb begin
            out_valid = is_call || is_ret;
            out_kind  = is_ret ? KIND_RET : KIND_CALL;
            out_addr  = in_target;
            out_tag   = in_tag;
         end
      end
   endgenerate

   // R3: function policy only ever yields call or return messages
   assert_kind_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_kind == KIND_CALL) || (out_kind == KIND_RET)));

endmodule

// File: rtl/ptrace_msg_fifo.sv
module ptrace_msg_fifo #(
   parameter int W     = 52,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         push_drop,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] dout
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [W-1:0]     mem_q [DEPTH];
   logic [PTR_W-1:0] rd_q, wr_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pop;
   logic             wr_en;

   initial begin
      assert (DEPTH >= 2) else $error("ptrace_msg_fifo: DEPTH must be at least 2");
      assert ((1 << PTR_W) == DEPTH) else $error("ptrace_msg_fifo: DEPTH must be a power of two");
   end

   assign out_valid = (cnt_q != '0);
   assign pop       = out_valid && out_ready;
   assign wr_en     = push && ((cnt_q != FULL_CNT) || pop);
   assign push_drop = push && !wr_en;
   assign dout      = mem_q[rd_q];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_en) wr_q <= wr_q + 1'b1;
         if (pop)   rd_q <= rd_q + 1'b1;
         cnt_q <= cnt_q + CNT_W'(wr_en) - CNT_W'(pop);
      end
   end

   // R9: occupancy never exceeds the depth
   assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT);

   // R9: an offered message stays put until taken
   assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(dout)));

   // R10: a lost message only happens with a full queue
   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      push_drop |-> (cnt_q == FULL_CNT && !out_ready));

endmodule

// File: rtl/ptrace_encoder.sv
module ptrace_encoder
   import ptrace_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int TAG_W      = 16,
   parameter int LIM_W      = 4,
   parameter int FIFO_DEPTH = 4,
   parameter bit FILTER_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trace_en,
   input  logic [1:0]        mode_sel,
   input  logic [LIM_W-1:0]  short_limit,
   input  logic              rt_valid,
   input  logic [ADDR_W-1:0] rt_pc,
   input  logic [2:0]        rt_class,
   input  logic [ADDR_W-1:0] rt_target,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [2:0]        m_kind,
   output logic [ADDR_W-1:0] m_addr,
   output logic [TAG_W-1:0]  m_tag,
   output logic              m_resync,
   output logic              overflow
);

   localparam int MSG_W = 1 + 3 + ADDR_W + TAG_W;

   initial begin
      assert (ADDR_W >= 8)  else $error("ptrace_encoder: ADDR_W too small");
      assert (TAG_W >= 2)   else $error("ptrace_encoder: TAG_W too small");
      assert (LIM_W >= 1)   else $error("ptrace_encoder: LIM_W too small");
      assert (FIFO_DEPTH >= 2) else $error("ptrace_encoder: FIFO_DEPTH too small");
   end

   logic              active;
   logic [1:0]        mode_q;
   logic              force_sync;
   logic [TAG_W-1:0]  cyc_q;
   logic [ADDR_W-1:0] last_pc_q;
   logic [ADDR_W-1:0] cur_pc;

   logic              flt_in_valid, flt_flush;
   logic              flt_valid;
   logic [2:0]        flt_kind;
   logic [ADDR_W-1:0] flt_addr;
   logic [TAG_W-1:0]  flt_tag;

   logic              gen_valid;
   logic [2:0]        gen_kind;
   logic [ADDR_W-1:0] gen_addr;
   logic [TAG_W-1:0]  gen_tag;

   logic              resync_pend_q;
   logic              ovf_q;
   logic              push_drop;
   logic [MSG_W-1:0]  fifo_din, fifo_dout;

   ptrace_mode_ctl #(.MODE_W(2)) mode_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .trace_en   (trace_en),
      .mode_sel   (mode_sel),
      .active     (active),
      .mode_q     (mode_q),
      .force_sync (force_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q     <= '0;
         last_pc_q <= '0;
      end else begin
         cyc_q <= cyc_q + 1'b1;
         if (rt_valid) last_pc_q <= rt_pc;
      end
   end

   assign cur_pc = rt_valid ? rt_pc : last_pc_q;

   assign flt_in_valid = rt_valid && active && !force_sync && (mode_q == MODE_FUNC);
   assign flt_flush    = !active || force_sync || (mode_q != MODE_FUNC);

   ptrace_call_filter #(
      .ADDR_W    (ADDR_W),
      .TAG_W     (TAG_W),
      .LIM_W     (LIM_W),
      .FILTER_EN (FILTER_EN)
   ) filt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flt_flush),
      .in_valid  (flt_in_valid),
      .in_class  (rt_class),
      .in_target (rt_target),
      .in_tag    (cyc_q),
      .limit     (short_limit),
      .out_valid (flt_valid),
      .out_kind  (flt_kind),
      .out_addr  (flt_addr),
      .out_tag   (flt_tag)
   );

   always_comb begin
      gen_valid = 1'b0;
      gen_kind  = KIND_SYNC;
      gen_addr  = cur_pc;
      gen_tag   = cyc_q;
      if (active) begin
         if (force_sync || (mode_q == MODE_SYNC)) begin
            gen_valid = 1'b1;
         end else if (mode_q == MODE_FUNC) begin
            gen_valid = flt_valid;
            gen_kind  = flt_kind;
            gen_addr  = flt_addr;
            gen_tag   = flt_tag;
         end else if (rt_valid && is_break(rt_class)) begin
            gen_valid = 1'b1;
            gen_kind  = class_to_kind(rt_class);
            gen_addr  = rt_target;
         end
      end
   end

   assign fifo_din = {resync_pend_q, gen_kind, gen_addr, gen_tag};

   ptrace_msg_fifo #(.W(MSG_W), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (gen_valid),
      .din       (fifo_din),
      .push_drop (push_drop),
      .out_valid (m_valid),
      .out_ready (m_ready),
      .dout      (fifo_dout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resync_pend_q <= 1'b0;
         ovf_q         <= 1'b0;
      end else begin
         if (push_drop) begin
            resync_pend_q <= 1'b1;
            ovf_q         <= 1'b1;
         end else if (gen_valid) begin
            resync_pend_q <= 1'b0;
         end
      end
   end

   assign {m_resync, m_kind, m_addr, m_tag} = fifo_dout;
   assign overflow = ovf_q;

   // R10: the overflow flag never clears without reset
   assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   // R2: running in sync mode yields a message every cycle
   assert_sync_continuous_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (trace_en && (mode_sel == MODE_SYNC)) |=> gen_valid);

   // R7: no message is generated in the cycle after the enable is low
   assert_disabled_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !trace_en |=> !gen_valid);

endmodule

// File: tb/ptrace_encoder_tb_top.sv
`timescale 1ns/1ps
module ptrace_encoder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trace_en = 1'b0;
   logic [1:0]  mode_sel = 2'd0;
   logic [3:0]  short_limit = 4'd0;
   logic        rt_valid = 1'b0;
   logic [31:0] rt_pc = '0;
   logic [2:0]  rt_class = 3'd0;
   logic [31:0] rt_target = '0;
   logic        m_valid;
   logic        m_ready = 1'b1;
   logic [2:0]  m_kind;
   logic [31:0] m_addr;
   logic [15:0] m_tag;
   logic        m_resync;
   logic        overflow;

   int n_checks = 0;
   int n_err = 0;

   logic [2:0]  lg_kind [0:63];
   logic [31:0] lg_addr [0:63];
   logic [15:0] lg_tag  [0:63];
   logic        lg_rs   [0:63];
   int          lg_n = 0;

   logic        s_valid;
   logic [31:0] s_addr;

   always #2 clk = ~clk;

   ptrace_encoder dut_i (
      .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .mode_sel(mode_sel),
      .short_limit(short_limit), .rt_valid(rt_valid), .rt_pc(rt_pc),
      .rt_class(rt_class), .rt_target(rt_target), .m_valid(m_valid),
      .m_ready(m_ready), .m_kind(m_kind), .m_addr(m_addr), .m_tag(m_tag),
      .m_resync(m_resync), .overflow(overflow)
   );

   always @(posedge clk) begin
      if (rst_n && m_valid && m_ready && lg_n < 64) begin
         lg_kind[lg_n] = m_kind;
         lg_addr[lg_n] = m_addr;
         lg_tag[lg_n]  = m_tag;
         lg_rs[lg_n]   = m_resync;
         lg_n = lg_n + 1;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [2:0] c, input logic [31:0] pc, input logic [31:0] tg);
      @(negedge clk);
      s_valid = m_valid;
      s_addr  = m_addr;
      rt_valid = v; rt_class = c; rt_pc = pc; rt_target = tg;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'h0, 32'h0);
   endtask

   task automatic clear_log();
      @(negedge clk);
      lg_n = 0;
   endtask

   task automatic entry(input string req, input int i, input logic [2:0] k, input logic [31:0] a);
      check({req, " kind"}, 64'(lg_kind[i]), 64'(k));
      check({req, " addr"}, 64'(lg_addr[i]), 64'(a));
   endtask

   function automatic int find_addr(input logic [31:0] a);
      for (int i = 0; i < lg_n; i++) if (lg_addr[i] == a) return i;
      return 0;
   endfunction

   task automatic t_reset();
      check("R9 reset m_valid", 64'(m_valid), 64'd0);
      check("R10 reset overflow", 64'(overflow), 64'd0);
   endtask

   task automatic t_flow();
      @(negedge clk); mode_sel = 2'd0; trace_en = 1'b1;
      idle(4);
      clear_log();
      step(1, 3'd0, 32'h100, 32'h0);
      step(1, 3'd1, 32'h104, 32'hA000);
      step(1, 3'd0, 32'hA000, 32'h0);
      check("R9 latency valid", 64'(s_valid), 64'd1);
      check("R9 latency addr", 64'(s_addr), 64'hA000);
      step(1, 3'd2, 32'hA004, 32'hA100);
      step(1, 3'd3, 32'hA100, 32'hA200);
      step(1, 3'd4, 32'hA200, 32'hA300);
      step(1, 3'd5, 32'hA300, 32'hA400);
      step(1, 3'd0, 32'hA400, 32'h0);
      idle(4);
      check("R1 flow count", 64'(lg_n), 64'd5);
      entry("R1 jump", 0, 3'd1, 32'hA000);
      entry("R1 branch", 1, 3'd1, 32'hA100);
      entry("R1 call", 2, 3'd2, 32'hA200);
      entry("R1 return", 3, 3'd3, 32'hA300);
      entry("R1 exception", 4, 3'd4, 32'hA400);
      check("R11 tag gap", 64'(16'(lg_tag[1] - lg_tag[0])), 64'd2);
      check("R11 tag gap next", 64'(16'(lg_tag[2] - lg_tag[1])), 64'd1);
   endtask

   task automatic t_sync();
      int i0;
      @(negedge clk); mode_sel = 2'd1;
      idle(4);
      clear_log();
      step(1, 3'd0, 32'h5000_0000, 32'h0);
      step(1, 3'd0, 32'h5000_0004, 32'h0);
      step(1, 3'd1, 32'h5000_0008, 32'h6000_0000);
      step(1, 3'd0, 32'h6000_0000, 32'h0);
      idle(4);
      i0 = find_addr(32'h5000_0000);
      entry("R2 sync s0", i0, 3'd0, 32'h5000_0000);
      entry("R2 sync s1", i0 + 1, 3'd0, 32'h5000_0004);
      entry("R2 sync jump pc", i0 + 2, 3'd0, 32'h5000_0008);
      entry("R2 sync s3", i0 + 3, 3'd0, 32'h6000_0000);
      entry("R2 sync idle pc", i0 + 5, 3'd0, 32'h6000_0000);
      check("R11 sync tag step", 64'(16'(lg_tag[i0 + 5] - lg_tag[i0])), 64'd5);
   endtask

   task automatic t_func_nofilter();
      @(negedge clk); mode_sel = 2'd2; short_limit = 4'd0;
      idle(4);
      clear_log();
      step(1, 3'd3, 32'h200, 32'hF000);
      step(1, 3'd1, 32'hF000, 32'hF100);
      step(1, 3'd2, 32'hF100, 32'hF200);
      step(1, 3'd5, 32'hF200, 32'hF300);
      step(1, 3'd0, 32'hF300, 32'h0);
      step(1, 3'd4, 32'hF304, 32'h204);
      idle(4);
      check("R3 function count", 64'(lg_n), 64'd2);
      entry("R6 call at once", 0, 3'd2, 32'hF000);
      entry("R3 return", 1, 3'd3, 32'h204);
      check("R6 call tag", 64'(16'(lg_tag[1] - lg_tag[0])), 64'd5);
   endtask

   task automatic t_filter();
      @(negedge clk); short_limit = 4'd3;
      idle(2);
      clear_log();
      step(1, 3'd3, 32'h300, 32'hC000);
      step(1, 3'd0, 32'hC000, 32'h0);
      step(1, 3'd0, 32'hC004, 32'h0);
      step(1, 3'd4, 32'hC008, 32'h304);
      idle(6);
      check("R4 short pair dropped", 64'(lg_n), 64'd0);
      clear_log();
      step(1, 3'd3, 32'h310, 32'hD000);
      step(1, 3'd0, 32'hD000, 32'h0);
      step(1, 3'd0, 32'hD004, 32'h0);
      step(1, 3'd0, 32'hD008, 32'h0);
      step(1, 3'd4, 32'hD00C, 32'h314);
      idle(4);
      check("R5 release count", 64'(lg_n), 64'd2);
      entry("R5 released call", 0, 3'd2, 32'hD000);
      entry("R5 return after", 1, 3'd3, 32'h314);
      check("R5 call keeps own tag", 64'(16'(lg_tag[1] - lg_tag[0])), 64'd4);
      clear_log();
      step(1, 3'd3, 32'h320, 32'hE000);
      step(1, 3'd3, 32'hE000, 32'hE800);
      step(1, 3'd4, 32'hE800, 32'hE004);
      idle(6);
      check("R5 nested count", 64'(lg_n), 64'd1);
      entry("R5 nested outer call", 0, 3'd2, 32'hE000);
   endtask

   task automatic t_disable();
      @(negedge clk); mode_sel = 2'd0; trace_en = 1'b0;
      idle(4);
      clear_log();
      step(1, 3'd1, 32'h400, 32'h9000);
      step(1, 3'd1, 32'h9000, 32'h9100);
      step(1, 3'd5, 32'h9100, 32'h9200);
      idle(4);
      check("R7 disabled silent", 64'(lg_n), 64'd0);
      clear_log();
      step(1, 3'd0, 32'h7700, 32'h0);
      trace_en = 1'b1;
      step(1, 3'd0, 32'h7704, 32'h0);
      step(1, 3'd0, 32'h7708, 32'h0);
      idle(4);
      check("R7 enable count", 64'(lg_n), 64'd1);
      entry("R7 enable sync", 0, 3'd0, 32'h7704);
   endtask

   task automatic t_mode_change();
      idle(2);
      clear_log();
      step(1, 3'd1, 32'h500, 32'h8000);
      mode_sel = 2'd2;
      step(1, 3'd1, 32'h8000, 32'h8100);
      step(1, 3'd1, 32'h8100, 32'h8200);
      idle(4);
      check("R8 change count", 64'(lg_n), 64'd2);
      entry("R8 old mode still", 0, 3'd1, 32'h8000);
      entry("R8 forced sync", 1, 3'd0, 32'h8000);
   endtask

   task automatic t_overflow();
      @(negedge clk); mode_sel = 2'd0;
      idle(4);
      check("R10 no overflow yet", 64'(overflow), 64'd0);
      clear_log();
      m_ready = 1'b0;
      for (int i = 0; i < 6; i++) step(1, 3'd1, 32'h600 + 32'(i), 32'hB000 + 32'(i));
      idle(2);
      check("R10 overflow set", 64'(overflow), 64'd1);
      check("R9 held valid", 64'(m_valid), 64'd1);
      check("R9 held addr", 64'(m_addr), 64'hB000);
      m_ready = 1'b1;
      idle(6);
      step(1, 3'd1, 32'h700, 32'hB006);
      step(1, 3'd1, 32'h704, 32'hB007);
      idle(4);
      check("R10 stored count", 64'(lg_n), 64'd6);
      for (int i = 0; i < 4; i++) begin
         entry("R9 order", i, 3'd1, 32'hB000 + 32'(i));
         check("R10 no resync", 64'(lg_rs[i]), 64'd0);
      end
      entry("R10 after loss", 4, 3'd1, 32'hB006);
      check("R10 resync mark", 64'(lg_rs[4]), 64'd1);
      check("R10 resync once", 64'(lg_rs[5]), 64'd0);
      check("R10 sticky", 64'(overflow), 64'd1);
   endtask

   initial begin
      #(4 * 100000);
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      idle(3);
      t_reset();
      t_flow();
      t_sync();
      t_func_nofilter();
      t_filter();
      t_disable();
      t_mode_change();
      t_overflow();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule